// File: doc/BRIEF.md
# Chained Page-Bounded DMA Engine

This block is a bus-master DMA engine that copies words between system memory and an I/O device without the processor moving any data. Software stages a descriptor in three holding registers: memory address, byte count, and a control word that selects the direction, the device and a last-in-chain marker. A command write pushes the staged descriptor into a four-entry internal queue. A second command bit starts the engine, which then walks the queue on its own.

No descriptor may reach past the end of the 4 KiB physical page it starts in. Longer transfers are built by chaining several one-page descriptors. For each descriptor the engine requests the shared bus, waits for the grant and then moves one 32-bit word in every cycle where the grant and the device's ready flag are both high. It drops the bus request between descriptors so that other masters can get the bus.

A single level interrupt reports the result. It rises once, after the descriptor flagged last has finished, or at once when a descriptor is rejected. It falls when software writes ones to clear the done and error bits.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset the status word (register index 4) reads zero, `irq` is low and `bus_req` is low.
- R2: Writing the command register (index 3) with bit 0 set copies the staged address (index 0), byte count (index 1) and control word (index 2) into the queue. The staged registers read back what was written. Status bits 6:4 give the number of queued entries. A push made while four entries are held is dropped.
- R3: With control bit 0 clear (device to memory), each cycle with `bus_gnt` and `dev_ready` both high moves one word. In that cycle `dev_pop` and `mem_we` are high and `mem_wdata` equals `dev_rdata`. The memory address starts at the descriptor address and rises by 4 per word. No word moves unless both inputs are high.
- R4: With control bit 0 set (memory to device), each moving cycle raises `mem_re` and `dev_push`, and `dev_wdata` equals `mem_rdata` at consecutive word addresses.
- R5: Words move only while `bus_req` and `bus_gnt` are both high. `bus_req` stays high from the grant wait until the last word of a descriptor, then drops for at least one cycle before the next descriptor. This gives exactly one falling edge of `bus_req` per descriptor.
- R6: A descriptor is rejected if it has a zero count, a count or address that is not a multiple of 4, or if its address offset within the page plus its count exceeds 4096. A rejected descriptor moves no data, flushes the queue, sets status bit 2 and raises `irq`.
- R7: Status bit 1 (done) and `irq` are set once, when the last word of a descriptor with control bit 8 set has moved. They are not set between earlier descriptors of the chain. While the engine works, status bit 0 (busy) reads 1.
- R8: Starting with an empty queue, or reaching an empty queue before a descriptor flagged last, sets the error bit and raises `irq`. Descriptors finished before that point keep their data.
- R9: Writing the status register with bit 1 or bit 2 set clears that bit. `irq` is high exactly while done or error is set.
- R10: A start command (command bit 1) written while busy does not disturb the running chain and sets status bit 3 (overrun). Writing 1 to bit 3 clears it.
- R11: `dev_sel` carries control bits 7:4 of the descriptor being moved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 3 | Register word index |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational) |
| bus_req | output | 1 | Shared-bus request |
| bus_gnt | input | 1 | Shared-bus grant |
| mem_addr | output | 32 | Memory byte address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, same cycle |
| dev_sel | output | 4 | Device identifier of the active descriptor |
| dev_ready | input | 1 | Device can supply or accept a word |
| dev_pop | output | 1 | Word taken from the device |
| dev_push | output | 1 | Word given to the device |
| dev_rdata | input | 32 | Word from the device |
| dev_wdata | output | 32 | Word to the device |
| irq | output | 1 | Interrupt, level |

## Verification
A wrong internal state shows at the ports as a word landing at the wrong address, a word carrying the wrong device tag, or a count of `bus_req` falling edges that does not match the chain length. Each of these can be seen by the end of the affected descriptor. A corrupted queue count or a lost last flag shows up when the chain finishes: `irq` is early, doubled or missing, or the error bit is set instead of done, and this is visible in the first status read after busy clears. The sweep crosses direction, chain length, device-ready throttling and grant interruption. It places each descriptor flush against the end of its page, so an off-by-one in the boundary arithmetic turns into either a false rejection or an out-of-page write.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int ADDR_W = 32;
  localparam int DEV_W  = 4;

  localparam logic [2:0] REG_ADDR  = 3'd0;
  localparam logic [2:0] REG_BYTES = 3'd1;
  localparam logic [2:0] REG_CTRL  = 3'd2;
  localparam logic [2:0] REG_CMD   = 3'd3;
  localparam logic [2:0] REG_STAT  = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_REQ, ST_XFER, ST_GAP
  } xfer_state_t;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] bytes;
    logic [DEV_W-1:0]  dev;
    logic              to_dev;
    logic              last;
  } dma_desc_t;

  // True when the descriptor is word aligned, non-empty and stays in its page.
  function automatic logic desc_fits(input dma_desc_t d, input int page_bits);
    logic [ADDR_W:0] page_sz;
    logic [ADDR_W:0] offs;
    logic [ADDR_W:0] end_off;
    page_sz = {{ADDR_W{1'b0}}, 1'b1} << page_bits;
    offs    = {1'b0, d.addr} & (page_sz - 1'b1);
    end_off = offs + {1'b0, d.bytes};
    return (d.bytes != '0) && (d.addr[1:0] == 2'b00) &&
           (d.bytes[1:0] == 2'b00) && (end_off <= page_sz);
  endfunction

  function automatic logic [ADDR_W-1:0] words_of(input logic [ADDR_W-1:0] b);
    return b >> 2;
  endfunction
endpackage

// File: rtl/dma_desc_queue.sv
module dma_desc_queue
  import dma_pkg::*;
#(
  parameter  int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  dma_desc_t        push_d,
  input  logic             pop,
  input  logic             flush,
  output dma_desc_t        head,
  output logic             empty,
  output logic             full,
  output logic [CNT_W-1:0] count
);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

  dma_desc_t        slots [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == FULL_CNT);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign head    = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) slots[wr_ptr] <= push_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/dma_csr_regs.sv
module dma_csr_regs
  import dma_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [2:0]        csr_addr,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  input  logic              busy,
  input  logic              ev_done,
  input  logic              ev_err,
  input  logic [CNT_W-1:0]  q_count,
  output dma_desc_t         stage,
  output logic              push_cmd,
  output logic              start_go,
  output logic              start_ignored,
  output logic              done_q,
  output logic              err_q,
  output logic              ovr_q
);
  logic [ADDR_W-1:0] stage_addr, stage_bytes;
  logic [DEV_W-1:0]  stage_dev;
  logic              stage_dir, stage_last;
  logic              hit_cmd, hit_stat, start_cmd;
  logic [31:0]       ctrl_word, stat_word;

  assign hit_cmd       = csr_we && (csr_addr == REG_CMD);
  assign hit_stat      = csr_we && (csr_addr == REG_STAT);
  assign push_cmd      = hit_cmd && csr_wdata[0];
  assign start_cmd     = hit_cmd && csr_wdata[1];
  assign start_go      = start_cmd && !busy;
  assign start_ignored = start_cmd && busy;

  assign stage = '{addr: stage_addr, bytes: stage_bytes, dev: stage_dev,
                   to_dev: stage_dir, last: stage_last};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_addr  <= '0;
      stage_bytes <= '0;
      stage_dev   <= '0;
      stage_dir   <= 1'b0;
      stage_last  <= 1'b0;
    end else if (csr_we) begin
      case (csr_addr)
        REG_ADDR:  stage_addr  <= csr_wdata;
        REG_BYTES: stage_bytes <= csr_wdata;
        REG_CTRL: begin
          stage_dir  <= csr_wdata[0];
          stage_dev  <= csr_wdata[4 +: DEV_W];
          stage_last <= csr_wdata[8];
        end
        default: ;
      endcase
    end
  end

  // Event sets take priority over a write-one-to-clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      done_q <= ev_done       | (done_q & ~(hit_stat & csr_wdata[1]));
      err_q  <= ev_err        | (err_q  & ~(hit_stat & csr_wdata[2]));
      ovr_q  <= start_ignored | (ovr_q  & ~(hit_stat & csr_wdata[3]));
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[0]          = stage_dir;
    ctrl_word[4 +: DEV_W] = stage_dev;
    ctrl_word[8]          = stage_last;
    stat_word = '0;
    stat_word[0]          = busy;
    stat_word[1]          = done_q;
    stat_word[2]          = err_q;
    stat_word[3]          = ovr_q;
    stat_word[4 +: CNT_W] = q_count;
    case (csr_addr)
      REG_ADDR:  csr_rdata = stage_addr;
      REG_BYTES: csr_rdata = stage_bytes;
      REG_CTRL:  csr_rdata = ctrl_word;
      REG_STAT:  csr_rdata = stat_word;
      default:   csr_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_pkg::*;
#(
  parameter int PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              q_empty,
  input  dma_desc_t         head,
  output logic              q_pop,
  output logic              q_flush,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic [DEV_W-1:0]  dev_sel,
  input  logic              dev_ready,
  output logic              dev_pop,
  output logic              dev_push,
  input  logic [31:0]       dev_rdata,
  output logic [31:0]       dev_wdata,
  output logic              busy,
  output logic              ev_done,
  output logic              ev_err,
  output logic              desc_end
);
  xfer_state_t       state, state_nx;
  logic [ADDR_W-1:0] cur_addr, words_left;
  logic [DEV_W-1:0]  cur_dev;
  logic              cur_dir, cur_last;
  logic              head_ok, move;

  assign head_ok  = !q_empty && desc_fits(head, PAGE_BITS);
  assign move     = (state == ST_XFER) && bus_gnt && dev_ready;
  assign desc_end = move && (words_left == ADDR_W'(1));
  assign ev_done  = desc_end && cur_last;
  assign ev_err   = (state == ST_CHECK) && !head_ok;
  assign q_pop    = (state == ST_CHECK) && head_ok;
  assign q_flush  = ev_err;
  assign busy     = (state != ST_IDLE);
  assign bus_req  = (state == ST_REQ) || (state == ST_XFER);

  assign mem_addr  = cur_addr;
  assign mem_we    = move && !cur_dir;
  assign dev_pop   = move && !cur_dir;
  assign mem_re    = move && cur_dir;
  assign dev_push  = move && cur_dir;
  assign mem_wdata = dev_rdata;
  assign dev_wdata = mem_rdata;
  assign dev_sel   = cur_dev;

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:  if (go) state_nx = ST_CHECK;
      ST_CHECK: state_nx = head_ok ? ST_REQ : ST_IDLE;
      ST_REQ:   if (bus_gnt) state_nx = ST_XFER;
      ST_XFER:  if (desc_end) state_nx = cur_last ? ST_IDLE : ST_GAP;
      ST_GAP:   state_nx = ST_CHECK;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cur_addr   <= '0;
      words_left <= '0;
      cur_dev    <= '0;
      cur_dir    <= 1'b0;
      cur_last   <= 1'b0;
    end else begin
      state <= state_nx;
      if (q_pop) begin
        cur_addr   <= head.addr;
        words_left <= words_of(head.bytes);
        cur_dev    <= head.dev;
        cur_dir    <= head.to_dev;
        cur_last   <= head.last;
      end else if (move) begin
        cur_addr   <= cur_addr + ADDR_W'(4);
        words_left <= words_left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
  import dma_pkg::*;
#(
  parameter  int QDEPTH    = 4,
  parameter  int PAGE_BITS = 12,
  localparam int CNT_W     = $clog2(QDEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_we,
  input  logic [2:0]  csr_addr,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  output logic        bus_req,
  input  logic        bus_gnt,
  output logic [31:0] mem_addr,
  output logic        mem_we,
  output logic        mem_re,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic [3:0]  dev_sel,
  input  logic        dev_ready,
  output logic        dev_pop,
  output logic        dev_push,
  input  logic [31:0] dev_rdata,
  output logic [31:0] dev_wdata,
  output logic        irq
);
  dma_desc_t        stage, head;
  logic             push_cmd, start_go, start_ignored;
  logic             done_q, err_q, ovr_q;
  logic             q_pop, q_flush, q_empty, q_full;
  logic [CNT_W-1:0] q_count;
  logic             busy, ev_done, ev_err, desc_end;

  dma_csr_regs #(.CNT_W(CNT_W)) csr_i (
    .clk, .rst_n, .csr_we, .csr_addr, .csr_wdata, .csr_rdata,
    .busy, .ev_done, .ev_err, .q_count,
    .stage, .push_cmd, .start_go, .start_ignored,
    .done_q, .err_q, .ovr_q
  );

  dma_desc_queue #(.DEPTH(QDEPTH)) queue_i (
    .clk, .rst_n, .push(push_cmd), .push_d(stage), .pop(q_pop),
    .flush(q_flush), .head, .empty(q_empty), .full(q_full), .count(q_count)
  );

  dma_xfer_fsm #(.PAGE_BITS(PAGE_BITS)) fsm_i (
    .clk, .rst_n, .go(start_go), .q_empty, .head, .q_pop, .q_flush,
    .bus_req, .bus_gnt, .mem_addr, .mem_we, .mem_re, .mem_wdata, .mem_rdata,
    .dev_sel, .dev_ready, .dev_pop, .dev_push, .dev_rdata, .dev_wdata,
    .busy, .ev_done, .ev_err, .desc_end
  );

  assign irq = done_q | err_q;
endmodule

// File: rtl/dma_chain_engine_chk.sv
module dma_chain_engine_chk #(
  parameter int QDEPTH = 4,
  parameter int CNT_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             csr_we,
  input logic [2:0]       csr_addr,
  input logic             bus_req,
  input logic             bus_gnt,
  input logic             mem_we,
  input logic             mem_re,
  input logic             dev_ready,
  input logic             irq,
  input logic             busy,
  input logic             ev_done,
  input logic             ev_err,
  input logic             desc_end,
  input logic             start_ignored,
  input logic             ovr_q,
  input logic [CNT_W-1:0] q_count
);
  p_move_granted_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> (bus_req && bus_gnt));

  p_move_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> dev_ready);

  p_release_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_end && !ev_done) |=> !bus_req);

  p_done_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> (irq && !busy));

  p_reject_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |=> (irq && (q_count == '0) && !bus_req));

  p_overrun_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_ignored |=> ovr_q);

  p_queue_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CNT_W'(QDEPTH));

  p_irq_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(csr_we && (csr_addr == 3'd4)));
endmodule

bind dma_chain_engine dma_chain_engine_chk #(.QDEPTH(QDEPTH), .CNT_W(CNT_W)) chk_i (
  .clk, .rst_n, .csr_we, .csr_addr, .bus_req, .bus_gnt, .mem_we, .mem_re,
  .dev_ready, .irq, .busy, .ev_done, .ev_err, .desc_end,
  .start_ignored, .ovr_q(ovr_q), .q_count
);

// File: tb/dma_chain_engine_tb.sv
module dma_chain_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [2:0]  csr_addr = 3'd0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        bus_req, bus_gnt = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we, mem_re;
  logic [3:0]  dev_sel;
  logic        dev_ready = 1'b0, dev_pop, dev_push;
  logic [31:0] dev_rdata, dev_wdata;
  logic        irq;

  int tests = 0, fails = 0;
  int rmode = 0, gmode = 0, ncyc = 0;
  int pop_cnt = 0, push_cnt = 0, mem_wr_cnt = 0, irq_rises = 0, req_falls = 0;
  logic irq_q = 1'b0, req_q = 1'b0;
  logic [31:0] mem [4096];
  logic [31:0] sink_data [4096];
  logic [3:0]  sink_id [4096];

  always #4ns clk = ~clk;

  function automatic logic [31:0] src_word(input logic [3:0] id, input int n);
    return 32'hC000_0000 | ({28'b0, id} << 20) | (32'(n) & 32'h000F_FFFF);
  endfunction

  function automatic logic [31:0] pat(input int i);
    return 32'h6000_0000 + 32'(i) * 32'd7;
  endfunction

  assign mem_rdata = mem[mem_addr[13:2]];
  assign dev_rdata = src_word(dev_sel, pop_cnt);

  dma_chain_engine dut_i (
    .clk, .rst_n, .csr_we, .csr_addr, .csr_wdata, .csr_rdata,
    .bus_req, .bus_gnt, .mem_addr, .mem_we, .mem_re, .mem_wdata, .mem_rdata,
    .dev_sel, .dev_ready, .dev_pop, .dev_push, .dev_rdata, .dev_wdata, .irq
  );

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr[13:2]] <= mem_wdata;
      mem_wr_cnt <= mem_wr_cnt + 1;
    end
    if (dev_pop) pop_cnt <= pop_cnt + 1;
    if (dev_push) begin
      sink_data[push_cnt[11:0]] <= dev_wdata;
      sink_id[push_cnt[11:0]]   <= dev_sel;
      push_cnt <= push_cnt + 1;
    end
    irq_q <= irq;
    req_q <= bus_req;
    if (irq && !irq_q) irq_rises <= irq_rises + 1;
    if (!bus_req && req_q) req_falls <= req_falls + 1;
  end

  // Device throttling and grant patterns, applied away from the active edge.
  initial forever begin
    @(negedge clk);
    ncyc = ncyc + 1;
    case (rmode)
      0: dev_ready = 1'b1;
      1: dev_ready = (ncyc % 2) == 0;
      default: dev_ready = (ncyc % 3) == 0;
    endcase
    bus_gnt = bus_req && ((gmode == 0) || ((ncyc % 4) != 1));
  end

  task automatic chk(input logic ok, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    csr_addr = a;
    #1ns d = csr_rdata;
  endtask

  task automatic push_desc(input int addr, input int bytes, input bit to_dev,
                           input int dev, input bit last);
    csr_wr(3'd0, 32'(addr));
    csr_wr(3'd1, 32'(bytes));
    csr_wr(3'd2, (32'(last) << 8) | ((32'(dev) & 32'hF) << 4) | 32'(to_dev));
    csr_wr(3'd3, 32'h1);
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    int n = 0;
    do begin
      csr_rd(3'd4, s);
      n++;
    end while (s[0] && n < 20000);
  endtask

  task automatic clear_all(input string tag);
    logic [31:0] s;
    csr_wr(3'd4, 32'hE);
    csr_rd(3'd4, s);
    chk(!irq && s[3:1] == 3'b000, {tag, " R9 W1C clears irq"}, {irq, s[30:0]}, 32'h0);
  endtask

  task automatic run_chain(input bit to_dev, input int nl, input int rm, input int gm);
    int wn[4], bw[4];
    int bp, bs, ir, rf, r, bad;
    logic [31:0] s;
    string tag;
    tag = $sformatf("dir=%0d links=%0d rm=%0d gm=%0d", to_dev, nl, rm, gm);
    rmode = rm; gmode = gm;
    for (int k = 0; k < nl; k++) begin
      wn[k] = 2 + k + rm;
      bw[k] = k * 1024 + 1024 - wn[k];
      for (int j = 0; j < wn[k]; j++) mem[bw[k] + j] = pat(bw[k] + j);
    end
    bp = pop_cnt; bs = push_cnt; ir = irq_rises; rf = req_falls;
    for (int k = 0; k < nl; k++) push_desc(bw[k] * 4, wn[k] * 4, to_dev, k + 1, k == nl - 1);
    csr_wr(3'd3, 32'h2);
    wait_idle();
    csr_rd(3'd4, s);
    chk(s[2:0] == 3'b010 && irq, {tag, " R7 done set, no error"}, s, 32'h2);
    chk(irq_rises - ir == 1, {tag, " R7 single irq per chain"}, 32'(irq_rises - ir), 32'd1);
    chk(req_falls - rf == nl, {tag, " R5 bus released per descriptor"},
        32'(req_falls - rf), 32'(nl));
    bad = 0; r = 0;
    for (int k = 0; k < nl; k++) begin
      for (int j = 0; j < wn[k]; j++) begin
        if (!to_dev) begin
          if (mem[bw[k] + j] != src_word(4'(k + 1), bp + r)) bad++;
        end else begin
          if (sink_data[12'(bs + r)] != pat(bw[k] + j) || sink_id[12'(bs + r)] != 4'(k + 1)) bad++;
        end
        r++;
      end
    end
    chk(bad == 0, {tag, to_dev ? " R4 R11 memory to device data" : " R3 R11 device to memory data"},
        32'(bad), 32'd0);
    clear_all(tag);
  endtask

  task automatic reject_case(input int addr, input int bytes, input string what);
    logic [31:0] s;
    int wc;
    wc = mem_wr_cnt;
    rmode = 0; gmode = 0;
    push_desc(addr, bytes, 1'b0, 3, 1'b1);
    push_desc(0, 8, 1'b0, 3, 1'b1);
    csr_wr(3'd3, 32'h2);
    wait_idle();
    csr_rd(3'd4, s);
    chk(s[2:1] == 2'b10 && irq && s[6:4] == 3'd0, {"R6 reject ", what}, s, 32'h4);
    chk(mem_wr_cnt == wc, {"R6 no data moved ", what}, 32'(mem_wr_cnt - wc), 32'd0);
    clear_all(what);
  endtask

  initial begin
    logic [31:0] s;
    int ir, bp;
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    csr_rd(3'd4, s);
    chk(s == 32'h0 && !irq && !bus_req, "R1 reset state", s, 32'h0);
    rst_n = 1'b1;
    csr_rd(3'd4, s);
    chk(s == 32'h0 && !irq && !bus_req, "R1 state after reset release", s, 32'h0);

    csr_wr(3'd0, 32'h0000_1230);
    csr_rd(3'd0, s);
    chk(s == 32'h0000_1230, "R2 staged address readback", s, 32'h1230);

    // Main sweep: direction x chain length x ready pattern x grant pattern.
    for (int d = 0; d < 2; d++)
      for (int nl = 1; nl <= 4; nl++)
        for (int rm = 0; rm < 3; rm++)
          for (int gm = 0; gm < 2; gm++)
            run_chain(d[0], nl, rm, gm);

    // Page boundary and alignment rejections.
    reject_case(4096 - 8, 12, "cross by one word");
    reject_case(4, 4096, "full page from offset 4");
    reject_case(64, 0, "zero count");
    reject_case(66, 8, "misaligned address");
    reject_case(64, 6, "misaligned count");

    // A whole page starting at its first byte is accepted.
    rmode = 0; gmode = 0;
    bp = pop_cnt;
    push_desc(8192, 4096, 1'b0, 9, 1'b1);
    csr_wr(3'd3, 32'h2);
    wait_idle();
    csr_rd(3'd4, s);
    chk(s[2:1] == 2'b01, "R6 exact full page accepted", s, 32'h2);
    chk(mem[3071] == src_word(4'd9, bp + 1023), "R3 last word of full page", mem[3071],
        src_word(4'd9, bp + 1023));
    clear_all("full page");

    // Start with nothing queued.
    csr_wr(3'd3, 32'h2);
    wait_idle();
    csr_rd(3'd4, s);
    chk(s[2:1] == 2'b10 && irq, "R8 start on empty queue", s, 32'h4);
    clear_all("empty start");

    // Chain without a last marker: data moves, then error.
    bp = pop_cnt;
    push_desc(400, 16, 1'b0, 5, 1'b0);
    csr_wr(3'd3, 32'h2);
    wait_idle();
    csr_rd(3'd4, s);
    chk(s[2:1] == 2'b10, "R8 unterminated chain errors", s, 32'h4);
    chk(mem[103] == src_word(4'd5, bp + 3), "R8 finished link kept data", mem[103],
        src_word(4'd5, bp + 3));
    clear_all("unterminated");

    // Queue capacity: fifth push dropped; four links then finish normally.
    for (int k = 0; k < 5; k++) push_desc(1024 + 64 * k, 8, 1'b0, 2, k == 3);
    csr_rd(3'd4, s);
    chk(s[6:4] == 3'd4, "R2 queue holds four", 32'(s[6:4]), 32'd4);
    ir = irq_rises;
    csr_wr(3'd3, 32'h2);
    wait_idle();
    csr_rd(3'd4, s);
    chk(s[2:1] == 2'b01 && s[6:4] == 3'd0 && irq_rises - ir == 1,
        "R2 four queued links drained", s, 32'h2);
    clear_all("queue full");

    // Start while busy: overrun flag, chain unaffected.
    ir = irq_rises;
    push_desc(2048, 256, 1'b0, 4, 1'b1);
    csr_wr(3'd3, 32'h2);
    csr_wr(3'd3, 32'h2);
    csr_rd(3'd4, s);
    chk(s[3] && s[0], "R10 overrun set while busy", s, 32'h9);
    wait_idle();
    csr_rd(3'd4, s);
    chk(s[3:1] == 3'b101 && irq_rises - ir == 1, "R10 chain completes once", s, 32'hA);
    csr_wr(3'd4, 32'h8);
    csr_rd(3'd4, s);
    chk(!s[3] && s[1] && irq, "R10 overrun W1C keeps done", s, 32'h2);
    csr_wr(3'd4, 32'h2);
    csr_rd(3'd4, s);
    chk(!irq && s[3:0] == 4'h0, "R9 done W1C drops irq", {31'b0, irq}, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests = tests + 1;
    fails = fails + 1;
    $display("FAIL watchdog expired R7 actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule